// File: doc/BRIEF.md
# Comparator Bus Column Slice

This block gathers comparator decisions from the analog blocks of several columns and turns them into clean digital signals. Each column has one continuous-time source and a parameterized number of switched-capacitor sources, each delivering one comparator bit. Every source passes through its own phase latch and can place its value on the column's shared bus under a drive enable. The bus value then goes through a column latch that follows phase 2 and can be forced open.

The column value is qualified by a gate signal. The gate is picked from a small set of digital block outputs by a single selector that serves the whole device. The gate marks the integration window of an incremental converter. The ungated column value appears in a read-only status vector. The gated value drives the digital data inputs and the decimator input. A rising edge of the gated value raises a column interrupt.

Phase 1 and phase 2 are sampled enables in the system clock domain. All outputs are registered, so they appear one clock after the inputs that produced them.

Top module: `cmpbus_slice`

## Requirements
- R1: While rst_n is low, all outputs (status_o, dig_o, dec_o, irq_o, conflict_o) are 0.
- R2: The column bus is the OR of the outputs of the sources whose drive enable is set. It is 0 when no enable is set. Source index 0 is the continuous-time source, and indices 1 to NSC are the switched-capacitor sources.
- R3: conflict_o of a column is 1 one clock after a cycle in which two or more of its drive enables are set. Otherwise it is 0.
- R4: The continuous-time source mode is ct_mode_i, bit 1 = latch enable and bit 0 = phase. The values 2'b00 and 2'b01 make the source transparent. 2'b10 makes it follow its input while ph1_i is high and hold otherwise. 2'b11 does the same with ph2_i.
- R5: A switched-capacitor source is always latched. Its sc_phase_i bit chooses the phase that opens it: 0 selects ph1_i and 1 selects ph2_i. While that phase is low, the source holds its last value.
- R6: With bypass clear, the column latch follows the bus while ph2_i is high. While ph2_i is low it holds the value from the last cycle in which ph2_i was high.
- R7: Setting a column's bypass_i bit makes its column latch follow the bus regardless of ph2_i.
- R8: The gate is gate_src_i[gate_sel_i]. For a column with gate_en_i set, a low gate forces dig_o and dec_o to 0 while status_o still shows the ungated value. With gate_en_i clear, the gate is ignored.
- R9: dec_o always equals dig_o. dig_o can only be 1 where status_o is 1.
- R10: irq_o of a column is a one-cycle pulse when dig_o rises and irq_en_i is set. With irq_en_i clear it stays 0.
- R11: Every output reflects the inputs of the previous clock edge. A change on an input does not appear at the outputs before the next rising clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ph1_i | input | 1 | Phase 1 enable |
| ph2_i | input | 1 | Phase 2 enable |
| cmp_i | input | NCOL x (NSC+1) | Comparator bit of every source, per column |
| drv_en_i | input | NCOL x (NSC+1) | Bus drive enable of every source |
| ct_mode_i | input | NCOL x 2 | Continuous-time source latch mode |
| sc_phase_i | input | NCOL x NSC | Switched-capacitor latch phase choice |
| bypass_i | input | NCOL | Force column latch transparent |
| gate_src_i | input | NGATE | Candidate gate signals from digital blocks |
| gate_sel_i | input | $clog2(NGATE) | Gate candidate selector |
| gate_en_i | input | NCOL | Apply the gate to the column |
| irq_en_i | input | NCOL | Column interrupt enable |
| status_o | output | NCOL | Ungated latched column value (read-only status) |
| dig_o | output | NCOL | Gated value to digital data inputs |
| dec_o | output | NCOL | Gated value to the decimator |
| irq_o | output | NCOL | Column interrupt pulse |
| conflict_o | output | NCOL | More than one driver enabled |

## Verification
Directed sequences on one column walk each latch mode through open, hold and reopen phases. The input value changes while the latch is closed, which tells a true hold apart from a transparent path or a latch opened on the wrong phase. Gate sequences toggle the selected candidate while the unselected ones carry the opposite level, which exposes a wrong selector index. A rising-then-steady gated value separates a pulsed interrupt from a level one. A long pseudo-random sweep covers all columns, drive-enable patterns including conflicts, phase combinations, modes and gate choices against an arithmetic model of every latch.

// File: rtl/cmpbus_pkg.sv
package cmpbus_pkg;

    typedef enum logic [1:0] {
        SRC_THRU = 2'd0,
        SRC_PH1  = 2'd1,
        SRC_PH2  = 2'd2
    } src_mode_e;

    typedef struct packed {
        logic col_hold;
        logic status;
        logic gated;
        logic irq;
        logic conflict;
    } col_state_t;

    // bit 1 = latch enable, bit 0 = phase (0: phase 1, 1: phase 2)
    function automatic src_mode_e ct_decode(input logic [1:0] cfg);
        if (!cfg[1])     return SRC_THRU;
        else if (cfg[0]) return SRC_PH2;
        else             return SRC_PH1;
    endfunction

    function automatic src_mode_e sc_decode(input logic phase_sel);
        return phase_sel ? SRC_PH2 : SRC_PH1;
    endfunction

endpackage

// File: rtl/cmpbus_src_latch.sv
module cmpbus_src_latch
    import cmpbus_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  src_mode_e mode_i,
    input  logic      ph1_i,
    input  logic      ph2_i,
    input  logic      cmp_i,
    output logic      q_o
);

    logic hold_d, hold_q;
    logic open_w;

    always_comb begin
        case (mode_i)
            SRC_THRU: open_w = 1'b1;
            SRC_PH1:  open_w = ph1_i;
            default:  open_w = ph2_i;
        endcase
        q_o    = open_w ? cmp_i : hold_q;
        hold_d = q_o;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) hold_q <= 1'b0;
        else        hold_q <= hold_d;
    end

endmodule

// File: rtl/cmpbus_gate_mux.sv
module cmpbus_gate_mux #(
    parameter int NGATE = 4,
    parameter int SELW  = (NGATE > 1) ? $clog2(NGATE) : 1
) (
    input  logic [NGATE-1:0] src_i,
    input  logic [SELW-1:0]  sel_i,
    output logic             gate_o
);

    localparam int NPAD = 1 << SELW;

    logic [NPAD-1:0] padded_w;

    generate
        if (NPAD > NGATE) begin : g_pad
            assign padded_w = {{(NPAD-NGATE){1'b0}}, src_i};
        end else begin : g_nopad
            assign padded_w = src_i;
        end
    endgenerate

    assign gate_o = padded_w[sel_i];

endmodule

// File: rtl/cmpbus_column.sv
module cmpbus_column
    import cmpbus_pkg::*;
#(
    parameter int NSC = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         ph1_i,
    input  logic         ph2_i,
    input  logic [NSC:0] cmp_i,
    input  logic [NSC:0] drv_en_i,
    input  logic [1:0]   ct_mode_i,
    input  logic [NSC-1:0] sc_phase_i,
    input  logic         bypass_i,
    input  logic         gate_i,
    input  logic         gate_en_i,
    input  logic         irq_en_i,
    output logic         status_o,
    output logic         dig_o,
    output logic         irq_o,
    output logic         conflict_o
);

    localparam int NSRC = NSC + 1;

    logic [NSRC-1:0] src_q_w;
    src_mode_e       mode_w [NSRC];

    generate
        for (genvar s = 0; s < NSRC; s++) begin : g_src
            if (s == 0) begin : g_ct
                assign mode_w[s] = ct_decode(ct_mode_i);
            end else begin : g_sc
                assign mode_w[s] = sc_decode(sc_phase_i[s-1]);
            end
            cmpbus_src_latch u_src (
                .clk    (clk),
                .rst_n  (rst_n),
                .mode_i (mode_w[s]),
                .ph1_i  (ph1_i),
                .ph2_i  (ph2_i),
                .cmp_i  (cmp_i[s]),
                .q_o    (src_q_w[s])
            );
        end
    endgenerate

    col_state_t st_d, st_q;
    logic bus_w, col_w, gate_ok_w;

    always_comb begin
        bus_w       = |(src_q_w & drv_en_i);
        col_w       = (ph2_i || bypass_i) ? bus_w : st_q.col_hold;
        gate_ok_w   = !gate_en_i || gate_i;
        st_d.col_hold = col_w;
        st_d.status   = col_w;
        st_d.gated    = col_w && gate_ok_w;
        st_d.irq      = irq_en_i && st_d.gated && !st_q.gated;
        st_d.conflict = (drv_en_i & (drv_en_i - 1'b1)) != '0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign status_o   = st_q.status;
    assign dig_o      = st_q.gated;
    assign irq_o      = st_q.irq;
    assign conflict_o = st_q.conflict;

    // R3: two or more drivers are flagged on the next cycle
    assert_conflict_flag_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ($countones(drv_en_i) > 1) |=> conflict_o);

    // R6: with phase 2 and bypass low the column value is held
    assert_column_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!ph2_i && !bypass_i) |=> (status_o == $past(st_q.col_hold)));

    // R8: a low applied gate blocks the digital output
    assert_gate_blocks_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (gate_en_i && !gate_i) |=> !dig_o);

    // R9: gated output implies ungated status
    assert_gated_within_status_R9: assert property (@(posedge clk) disable iff (!rst_n)
        dig_o |-> status_o);

    // R10: interrupt lasts one cycle
    assert_irq_single_R10: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |=> !irq_o);

    // R10: disabled interrupt never fires
    assert_irq_masked_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !irq_en_i |=> !irq_o);

endmodule

// File: rtl/cmpbus_slice.sv
module cmpbus_slice
    import cmpbus_pkg::*;
#(
    parameter int NCOL  = 4,
    parameter int NSC   = 2,
    parameter int NGATE = 4,
    parameter int SELW  = (NGATE > 1) ? $clog2(NGATE) : 1
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      ph1_i,
    input  logic                      ph2_i,
    input  logic [NCOL-1:0][NSC:0]    cmp_i,
    input  logic [NCOL-1:0][NSC:0]    drv_en_i,
    input  logic [NCOL-1:0][1:0]      ct_mode_i,
    input  logic [NCOL-1:0][NSC-1:0]  sc_phase_i,
    input  logic [NCOL-1:0]           bypass_i,
    input  logic [NGATE-1:0]          gate_src_i,
    input  logic [SELW-1:0]           gate_sel_i,
    input  logic [NCOL-1:0]           gate_en_i,
    input  logic [NCOL-1:0]           irq_en_i,
    output logic [NCOL-1:0]           status_o,
    output logic [NCOL-1:0]           dig_o,
    output logic [NCOL-1:0]           dec_o,
    output logic [NCOL-1:0]           irq_o,
    output logic [NCOL-1:0]           conflict_o
);

    logic gate_w;

    cmpbus_gate_mux #(.NGATE(NGATE), .SELW(SELW)) u_gate (
        .src_i  (gate_src_i),
        .sel_i  (gate_sel_i),
        .gate_o (gate_w)
    );

    generate
        for (genvar c = 0; c < NCOL; c++) begin : g_col
            cmpbus_column #(.NSC(NSC)) u_col (
                .clk        (clk),
                .rst_n      (rst_n),
                .ph1_i      (ph1_i),
                .ph2_i      (ph2_i),
                .cmp_i      (cmp_i[c]),
                .drv_en_i   (drv_en_i[c]),
                .ct_mode_i  (ct_mode_i[c]),
                .sc_phase_i (sc_phase_i[c]),
                .bypass_i   (bypass_i[c]),
                .gate_i     (gate_w),
                .gate_en_i  (gate_en_i[c]),
                .irq_en_i   (irq_en_i[c]),
                .status_o   (status_o[c]),
                .dig_o      (dig_o[c]),
                .irq_o      (irq_o[c]),
                .conflict_o (conflict_o[c])
            );
        end
    endgenerate

    assign dec_o = dig_o;

    // R1: outputs are cleared one cycle into reset
    assert_reset_clear_R1: assert property (@(posedge clk)
        $past(!rst_n) |-> (status_o == '0 && dig_o == '0 && irq_o == '0 && conflict_o == '0));

endmodule

// File: tb/cmpbus_slice_bench.sv
`timescale 1ns/1ps
module cmpbus_slice_bench;

    localparam int NCOL = 4;
    localparam int NSC  = 2;
    localparam int NSRC = NSC + 1;
    localparam int NG   = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ph1_i = 1'b0, ph2_i = 1'b0;
    logic [NCOL-1:0][NSC:0]   cmp_i = '0, drv_en_i = '0;
    logic [NCOL-1:0][1:0]     ct_mode_i = '0;
    logic [NCOL-1:0][NSC-1:0] sc_phase_i = '0;
    logic [NCOL-1:0] bypass_i = '0, gate_en_i = '0, irq_en_i = '0;
    logic [NG-1:0]   gate_src_i = '0;
    logic [1:0]      gate_sel_i = '0;
    logic [NCOL-1:0] status_o, dig_o, dec_o, irq_o, conflict_o;

    always #4 clk = ~clk;

    cmpbus_slice u_cmpbus_slice (
        .clk(clk), .rst_n(rst_n), .ph1_i(ph1_i), .ph2_i(ph2_i),
        .cmp_i(cmp_i), .drv_en_i(drv_en_i), .ct_mode_i(ct_mode_i),
        .sc_phase_i(sc_phase_i), .bypass_i(bypass_i), .gate_src_i(gate_src_i),
        .gate_sel_i(gate_sel_i), .gate_en_i(gate_en_i), .irq_en_i(irq_en_i),
        .status_o(status_o), .dig_o(dig_o), .dec_o(dec_o), .irq_o(irq_o),
        .conflict_o(conflict_o)
    );

    int checks = 0, errors = 0;
    bit finished = 0;

    // model state
    logic [NCOL-1:0][NSRC-1:0] m_src;
    logic [NCOL-1:0] m_col, m_prev_g;
    logic [NCOL-1:0] e_status, e_dig, e_irq, e_conf;

    task automatic chk(input string tag, input logic [NCOL-1:0] act, input logic [NCOL-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %b expected %b at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic model_reset();
        m_src = '0; m_col = '0; m_prev_g = '0;
        e_status = '0; e_dig = '0; e_irq = '0; e_conf = '0;
    endtask

    task automatic model_update();
        for (int c = 0; c < NCOL; c++) begin
            logic bus, gate, g;
            int n;
            bus = 1'b0; n = 0;
            for (int s = 0; s < NSRC; s++) begin
                logic open;
                if (s == 0) open = !ct_mode_i[c][1] ? 1'b1 : (ct_mode_i[c][0] ? ph2_i : ph1_i);
                else        open = sc_phase_i[c][s-1] ? ph2_i : ph1_i;
                if (open) m_src[c][s] = cmp_i[c][s];
                if (drv_en_i[c][s]) begin
                    bus = bus | m_src[c][s];
                    n++;
                end
            end
            if (ph2_i || bypass_i[c]) m_col[c] = bus;
            gate = gate_src_i[gate_sel_i];
            g = m_col[c] & (!gate_en_i[c] | gate);
            e_irq[c]    = irq_en_i[c] & g & !m_prev_g[c];
            m_prev_g[c] = g;
            e_status[c] = m_col[c];
            e_dig[c]    = g;
            e_conf[c]   = (n > 1);
        end
    endtask

    task automatic step();
        @(posedge clk);
        model_update();
        @(negedge clk);
        chk("R6 status model", status_o, e_status);
        chk("R8 dig model", dig_o, e_dig);
        chk("R9 dec model", dec_o, e_dig);
        chk("R10 irq model", irq_o, e_irq);
        chk("R3 conflict model", conflict_o, e_conf);
    endtask

    task automatic chk1(input string tag, input logic act, input logic exp);
        chk(tag, {3'b0, act}, {3'b0, exp});
    endtask

    logic [31:0] lfsr = 32'hACE1_2468;
    function automatic logic [31:0] nxt(input logic [31:0] v);
        return {v[30:0], v[31] ^ v[21] ^ v[1] ^ v[0]};
    endfunction

    initial begin
        model_reset();
        // R1: reset holds outputs low even with active stimulus
        cmp_i = '1; for (int c = 0; c < NCOL; c++) drv_en_i[c] = 3'b001;
        bypass_i = '1; irq_en_i = '1;
        repeat (3) @(negedge clk);
        chk("R1 status", status_o, '0);
        chk("R1 dig", dig_o, '0);
        chk("R1 irq", irq_o, '0);
        chk("R1 conflict", conflict_o, '0);
        cmp_i = '0; drv_en_i = '0; bypass_i = '0; irq_en_i = '0;
        rst_n = 1'b1;
        step();

        // R11 and R2 on column 0, continuous-time transparent
        drv_en_i[0] = 3'b001; ct_mode_i[0] = 2'b00; bypass_i[0] = 1'b1; cmp_i[0] = 3'b001;
        #1 chk1("R11 no change before edge", status_o[0], 1'b0);
        step(); chk1("R2 single driver", status_o[0], 1'b1);
        drv_en_i[0] = 3'b000; step(); chk1("R2 no driver reads 0", status_o[0], 1'b0);

        // R4 continuous-time latch modes
        drv_en_i[0] = 3'b001; ct_mode_i[0] = 2'b10; ph1_i = 1'b1; cmp_i[0] = 3'b000;
        step(); chk1("R4 ph1 open", status_o[0], 1'b0);
        ph1_i = 1'b0; cmp_i[0] = 3'b001;
        step(); chk1("R4 ph1 hold", status_o[0], 1'b0);
        ph1_i = 1'b1; step(); chk1("R4 ph1 reopen", status_o[0], 1'b1);
        ct_mode_i[0] = 2'b11; cmp_i[0] = 3'b000;
        step(); chk1("R4 ph2 mode ignores ph1", status_o[0], 1'b1);
        ph1_i = 1'b0;

        // R5 switched-capacitor source 1
        drv_en_i[0] = 3'b010; sc_phase_i[0] = 2'b00; ph1_i = 1'b1; cmp_i[0] = 3'b010;
        step(); chk1("R5 sc ph1 open", status_o[0], 1'b1);
        ph1_i = 1'b0; cmp_i[0] = 3'b000;
        step(); chk1("R5 sc hold", status_o[0], 1'b1);
        sc_phase_i[0] = 2'b01; ph2_i = 1'b1;
        step(); chk1("R5 sc ph2 open", status_o[0], 1'b0);
        ph2_i = 1'b0;

        // R6 column latch follows phase 2
        drv_en_i[0] = 3'b001; ct_mode_i[0] = 2'b00; bypass_i[0] = 1'b0;
        ph2_i = 1'b1; cmp_i[0] = 3'b001;
        step(); chk1("R6 ph2 high follows", status_o[0], 1'b1);
        ph2_i = 1'b0; cmp_i[0] = 3'b000;
        step(); chk1("R6 ph2 low holds", status_o[0], 1'b1);
        ph2_i = 1'b1; step(); chk1("R6 ph2 reopen", status_o[0], 1'b0);
        ph2_i = 1'b0;

        // R7 bypass
        bypass_i[0] = 1'b1; cmp_i[0] = 3'b001;
        step(); chk1("R7 bypass follows", status_o[0], 1'b1);
        cmp_i[0] = 3'b000;
        step(); chk1("R7 bypass follows low", status_o[0], 1'b0);

        // R8 / R9 gating
        cmp_i[0] = 3'b001; gate_en_i[0] = 1'b1; gate_sel_i = 2'd2; gate_src_i = 4'b0100;
        step(); chk1("R8 gate high passes", dig_o[0], 1'b1);
        chk1("R9 dec equals dig", dec_o[0], 1'b1);
        gate_src_i = 4'b1011;
        step(); chk1("R8 gate low blocks", dig_o[0], 1'b0);
        chk1("R8 status ungated", status_o[0], 1'b1);
        chk1("R9 dec blocked", dec_o[0], 1'b0);
        gate_en_i[0] = 1'b0;
        step(); chk1("R8 gate ignored", dig_o[0], 1'b1);

        // R10 interrupt
        irq_en_i[0] = 1'b1; cmp_i[0] = 3'b000;
        step(); chk1("R10 no irq on fall", irq_o[0], 1'b0);
        cmp_i[0] = 3'b001;
        step(); chk1("R10 irq on rise", irq_o[0], 1'b1);
        step(); chk1("R10 irq one cycle", irq_o[0], 1'b0);
        irq_en_i[0] = 1'b0; cmp_i[0] = 3'b000; step();
        cmp_i[0] = 3'b001;
        step(); chk1("R10 masked irq", irq_o[0], 1'b0);

        // R3 conflict
        drv_en_i[0] = 3'b011;
        step(); chk1("R3 conflict set", conflict_o[0], 1'b1);
        drv_en_i[0] = 3'b010;
        step(); chk1("R3 conflict clear", conflict_o[0], 1'b0);

        // sweep all columns with pseudo-random stimulus
        for (int i = 0; i < 4000; i++) begin
            lfsr = nxt(lfsr); cmp_i = lfsr[11:0]; ph1_i = lfsr[12]; ph2_i = lfsr[13];
            bypass_i = lfsr[17:14]; gate_sel_i = lfsr[19:18]; gate_src_i = lfsr[23:20];
            gate_en_i = lfsr[27:24]; irq_en_i = lfsr[31:28];
            lfsr = nxt(lfsr); drv_en_i = lfsr[11:0]; ct_mode_i = lfsr[19:12];
            sc_phase_i = lfsr[27:20];
            if (lfsr[28]) for (int c = 0; c < NCOL; c++) drv_en_i[c] = 3'b001 << (lfsr[30:29] % 3);
            lfsr = nxt(lfsr);
            step();
        end

        finished = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule